// File: doc/BRIEF.md
# External Oscillator Control and System Clock Selector

This block controls an external oscillator and chooses the source of the system clock. A 3-bit mode register turns the external path off or runs it in one of the external CMOS clock, RC, capacitor or crystal modes. The CMOS and crystal modes each have a variant that passes only every second rising edge of the external input. A read-only valid flag reports that the external source is stable. In this model a settling counter sets that flag. The count is long for crystal modes and short for all other active modes.

A separate 3-bit select register chooses the system clock from five sources: the internal oscillator, the external oscillator, half of the clock multiplier, the full clock multiplier, or the low-frequency oscillator. All sources arrive as ordinary signals sampled by the block clock. The internal, multiplier and low-frequency sources are single-cycle ticks. The external source is a level whose rising edges are detected after a parameterised synchronizer. The output is a registered clock-enable stream, and it follows the selected tick one cycle later.

Reserved select codes are ignored. A request for the external source while the valid flag is low is held. The switch happens only once the flag rises.

Top module: `xosc_clk_ctrl`

## Requirements
- R1: After reset the mode reads 000 (off), the valid flag is low, the active source reads 000 (internal) and clk_en is low.
- R2: In mode codes 000 and 001 (off) the valid flag never rises, and the external input produces no clock enables.
- R3: In the cycle after any mode write, the valid flag reads low.
- R4: After a write of mode 110 or 111 (crystal), the valid flag rises exactly XTAL_SETTLE clock edges after the write edge. After a write of 010, 011, 100 or 101, it rises exactly CMOS_SETTLE edges after the write edge. Once high, it stays high until the next mode write.
- R5: In modes 010, 100, 101 and 110 with the valid flag high, each rising edge of ext_in yields exactly one clk_en pulse when the external source is active.
- R6: In modes 011 and 111 (divide by two), only every second rising edge of ext_in yields a pulse. The first pulse after a mode write comes on the second rising edge seen with the valid flag high.
- R7: Select codes map as follows: 000 = int_tick, 001 = external path, 010 = every second mult_tick, 011 = mult_tick, 100 = lfo_tick. clk_en is the chosen tick delayed by one clock.
- R8: A select write with code 101, 110 or 111 leaves the active source unchanged.
- R9: Selecting 001 while the valid flag is high switches at once. Selecting 001 while it is low keeps the current source, and the switch happens on the edge after the flag is first seen high.
- R10: A legal non-external select write cancels a held external request and takes effect at once. The held request does not come back when the flag later rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr | input | 1 | Write strobe for the oscillator mode register |
| mode_wdata | input | 3 | New oscillator mode code |
| sel_wr | input | 1 | Write strobe for the clock select register |
| sel_wdata | input | 3 | New clock select code |
| ext_in | input | 1 | External oscillator level |
| int_tick | input | 1 | Internal oscillator tick |
| mult_tick | input | 1 | Clock multiplier tick |
| lfo_tick | input | 1 | Low-frequency oscillator tick |
| osc_mode | output | 3 | Current oscillator mode |
| osc_valid | output | 1 | External source stable flag |
| active_src | output | 3 | Source currently driving clk_en |
| clk_en | output | 1 | Selected system clock enable |

## Verification
On every cycle, the embedded properties check several things: the valid flag clears after each mode write, stays low in the off modes and holds once set; the active source never takes a reserved code and is not disturbed by reserved writes; the external source is never adopted while the flag is low; and legal non-external writes land immediately. Some behaviour only the bench scenarios can show, because it needs counting over windows. This covers the exact settling lengths for each mode code, the pulse counts through the divide-by-two modes including where the first pulse lands, the tick rate of each selectable source, and the timing of a held external switch relative to the flag.

// File: rtl/xosc_pkg.sv
package xosc_pkg;

   typedef enum logic [2:0] {
      SRC_INT  = 3'd0,
      SRC_EXT  = 3'd1,
      SRC_MULH = 3'd2,
      SRC_MUL  = 3'd3,
      SRC_LFO  = 3'd4
   } src_e;

   localparam int NUM_SRC  = 5;
   localparam int CODE_W   = 3;

   // external path enabled for codes 010..111
   function automatic logic mode_is_on(input logic [CODE_W-1:0] m);
      return m[2] | m[1];
   endfunction

   // divide-by-two variants: 011 and 111
   function automatic logic mode_is_div(input logic [CODE_W-1:0] m);
      return m[1] & m[0];
   endfunction

   // crystal variants: 110 and 111
   function automatic logic mode_is_xtal(input logic [CODE_W-1:0] m);
      return m[2] & m[1];
   endfunction

   function automatic logic sel_is_legal(input logic [CODE_W-1:0] c);
      return int'(c) < NUM_SRC;
   endfunction

endpackage

// File: rtl/xosc_settle.sv
module xosc_settle
   import xosc_pkg::*;
#(
   parameter int XTAL_SETTLE = 24000,
   parameter int CMOS_SETTLE = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_wr,
   input  logic [CODE_W-1:0] mode_q,
   output logic              valid
);
   localparam int CNT_W = $clog2(XTAL_SETTLE + 1);
   localparam logic [CNT_W-1:0] XTAL_LAST = CNT_W'(XTAL_SETTLE - 1);
   localparam logic [CNT_W-1:0] CMOS_LAST = CNT_W'(CMOS_SETTLE - 1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] last;
   logic             valid_q;

   assign last  = mode_is_xtal(mode_q) ? XTAL_LAST : CMOS_LAST;
   assign valid = valid_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         valid_q <= 1'b0;
      end else if (mode_wr) begin
         cnt_q   <= '0;
         valid_q <= 1'b0;
      end else if (mode_is_on(mode_q) && !valid_q) begin
         if (cnt_q == last) valid_q <= 1'b1;
         else               cnt_q   <= cnt_q + 1'b1;
      end
   end

   assert_valid_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
      mode_wr |=> !valid_q);

   assert_off_never_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_is_on(mode_q) && !mode_wr) |=> !valid_q);

   assert_valid_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_q && !mode_wr) |=> valid_q);

endmodule

// File: rtl/xosc_ext_path.sv
module xosc_ext_path
   import xosc_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ext_in,
   input  logic              mode_wr,
   input  logic [CODE_W-1:0] mode_q,
   input  logic              valid,
   output logic              ext_tick
);
   logic ext_s;
   logic prev_q;
   logic half_q;
   logic rise;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign ext_s = ext_in;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sh_q <= '0;
            end else begin
               sh_q[0] <= ext_in;
               for (int i = 1; i < SYNC_STAGES; i++) sh_q[i] <= sh_q[i-1];
            end
         end
         assign ext_s = sh_q[SYNC_STAGES-1];
      end
   endgenerate

   assign rise = ext_s & ~prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         half_q <= 1'b0;
      end else begin
         prev_q <= ext_s;
         if (mode_wr)            half_q <= 1'b0;
         else if (rise && valid) half_q <= ~half_q;
      end
   end

   assign ext_tick = rise & valid & (mode_is_div(mode_q) ? half_q : 1'b1);

   assert_ext_needs_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ext_tick |-> valid);

   assert_div_skips_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_is_div(mode_q) && rise && valid && !half_q && !mode_wr) |=> half_q);

endmodule

// File: rtl/xosc_src_sel.sv
module xosc_src_sel
   import xosc_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_wr,
   input  logic [CODE_W-1:0] sel_wdata,
   input  logic              valid,
   input  logic              int_tick,
   input  logic              ext_tick,
   input  logic              mult_tick,
   input  logic              lfo_tick,
   output logic [CODE_W-1:0] active_src,
   output logic              clk_en
);
   src_e               act_q;
   logic               pend_q;
   logic               mh_q;
   logic [NUM_SRC-1:0] tick_v;
   logic               legal_wr;

   assign legal_wr = sel_wr && sel_is_legal(sel_wdata);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q  <= SRC_INT;
         pend_q <= 1'b0;
      end else if (legal_wr) begin
         if (src_e'(sel_wdata) == SRC_EXT && !valid) begin
            pend_q <= 1'b1;
         end else begin
            act_q  <= src_e'(sel_wdata);
            pend_q <= 1'b0;
         end
      end else if (pend_q && valid) begin
         act_q  <= SRC_EXT;
         pend_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         mh_q <= 1'b0;
      else if (mult_tick) mh_q <= ~mh_q;
   end

   generate
      for (genvar s = 0; s < NUM_SRC; s++) begin : g_tick
         if (s == int'(SRC_INT))       begin : g_i assign tick_v[s] = int_tick;          end
         else if (s == int'(SRC_EXT))  begin : g_e assign tick_v[s] = ext_tick;          end
         else if (s == int'(SRC_MULH)) begin : g_h assign tick_v[s] = mult_tick & mh_q;  end
         else if (s == int'(SRC_MUL))  begin : g_m assign tick_v[s] = mult_tick;         end
         else                          begin : g_l assign tick_v[s] = lfo_tick;          end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) clk_en <= 1'b0;
      else        clk_en <= tick_v[act_q];
   end

   assign active_src = act_q;

   assert_sel_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
      sel_is_legal(act_q));

   assert_reserved_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_wr && !sel_is_legal(sel_wdata) && !(pend_q && valid)) |=> $stable(act_q));

   assert_ext_waits_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (act_q != SRC_EXT && !valid) |=> act_q != SRC_EXT);

   assert_other_wr_lands_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (legal_wr && sel_wdata != CODE_W'(SRC_EXT)) |=> (act_q == $past(sel_wdata)) && !pend_q);

endmodule

// File: rtl/xosc_clk_ctrl.sv
module xosc_clk_ctrl
   import xosc_pkg::*;
#(
   parameter int XTAL_SETTLE = 24000,
   parameter int CMOS_SETTLE = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       mode_wr,
   input  logic [2:0] mode_wdata,
   input  logic       sel_wr,
   input  logic [2:0] sel_wdata,
   input  logic       ext_in,
   input  logic       int_tick,
   input  logic       mult_tick,
   input  logic       lfo_tick,
   output logic [2:0] osc_mode,
   output logic       osc_valid,
   output logic [2:0] active_src,
   output logic       clk_en
);
   generate
      if (CMOS_SETTLE < 1)           begin : g_chk_cmos $error("CMOS_SETTLE must be at least 1"); end
      if (XTAL_SETTLE < CMOS_SETTLE) begin : g_chk_xtal $error("XTAL_SETTLE must not be below CMOS_SETTLE"); end
      if (SYNC_STAGES < 0)           begin : g_chk_sync $error("SYNC_STAGES must not be negative"); end
   endgenerate

   logic [CODE_W-1:0] mode_q;
   logic              valid;
   logic              ext_tick;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mode_q <= '0;
      else if (mode_wr) mode_q <= mode_wdata;
   end

   xosc_settle #(
      .XTAL_SETTLE(XTAL_SETTLE),
      .CMOS_SETTLE(CMOS_SETTLE)
   ) u_settle (
      .clk    (clk),
      .rst_n  (rst_n),
      .mode_wr(mode_wr),
      .mode_q (mode_q),
      .valid  (valid)
   );

   xosc_ext_path #(
      .SYNC_STAGES(SYNC_STAGES)
   ) u_ext (
      .clk     (clk),
      .rst_n   (rst_n),
      .ext_in  (ext_in),
      .mode_wr (mode_wr),
      .mode_q  (mode_q),
      .valid   (valid),
      .ext_tick(ext_tick)
   );

   xosc_src_sel u_sel (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel_wr    (sel_wr),
      .sel_wdata (sel_wdata),
      .valid     (valid),
      .int_tick  (int_tick),
      .ext_tick  (ext_tick),
      .mult_tick (mult_tick),
      .lfo_tick  (lfo_tick),
      .active_src(active_src),
      .clk_en    (clk_en)
   );

   assign osc_mode  = mode_q;
   assign osc_valid = valid;

   assert_mode_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
      mode_wr |=> osc_mode == $past(mode_wdata));

endmodule

// File: tb/xosc_clk_ctrl_bench.sv
module xosc_clk_ctrl_bench;
   localparam int XS = 20;
   localparam int CS = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mode_wr = 1'b0;
   logic [2:0] mode_wdata = 3'd0;
   logic       sel_wr = 1'b0;
   logic [2:0] sel_wdata = 3'd0;
   logic       ext_in = 1'b0;
   logic       int_tick = 1'b0;
   logic       mult_tick = 1'b0;
   logic       lfo_tick = 1'b0;
   logic [2:0] osc_mode;
   logic       osc_valid;
   logic [2:0] active_src;
   logic       clk_en;

   int n_chk = 0;
   int n_fail = 0;
   int en_cnt = 0;
   bit cnt_on = 1'b0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   xosc_clk_ctrl #(.XTAL_SETTLE(XS), .CMOS_SETTLE(CS), .SYNC_STAGES(2)) u_xosc_clk_ctrl (
      .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
      .sel_wr(sel_wr), .sel_wdata(sel_wdata), .ext_in(ext_in), .int_tick(int_tick),
      .mult_tick(mult_tick), .lfo_tick(lfo_tick), .osc_mode(osc_mode),
      .osc_valid(osc_valid), .active_src(active_src), .clk_en(clk_en)
   );

   always @(negedge clk) if (cnt_on && clk_en) en_cnt = en_cnt + 1;

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic write_mode(input logic [2:0] m);
      @(negedge clk); mode_wr = 1'b1; mode_wdata = m;
      @(negedge clk); mode_wr = 1'b0;
   endtask

   task automatic write_sel(input logic [2:0] c);
      @(negedge clk); sel_wr = 1'b1; sel_wdata = c;
      @(negedge clk); sel_wr = 1'b0;
   endtask

   task automatic wait_valid(output int n);
      n = 0;
      while (!osc_valid && n < XS + 10) begin
         @(negedge clk); n++;
      end
   endtask

   task automatic count_ext(input int k, output int n);
      repeat (3) @(negedge clk);
      en_cnt = 0; cnt_on = 1'b1;
      repeat (k) begin
         ext_in = 1'b1; @(negedge clk); @(negedge clk);
         ext_in = 1'b0; @(negedge clk); @(negedge clk);
      end
      repeat (6) @(negedge clk);
      cnt_on = 1'b0; n = en_cnt;
   endtask

   task automatic count_pattern(output int n);
      repeat (3) @(negedge clk);
      en_cnt = 0; cnt_on = 1'b1;
      for (int i = 0; i < 24; i++) begin
         int_tick = 1'b1; mult_tick = (i % 2 == 0); lfo_tick = (i % 3 == 0);
         @(negedge clk);
      end
      int_tick = 1'b0; mult_tick = 1'b0; lfo_tick = 1'b0;
      repeat (4) @(negedge clk);
      cnt_on = 1'b0; n = en_cnt;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++; n_chk++;
         $display("FAIL watchdog: actual 1 expected 0");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 mode", osc_mode, 0);
      check("R1 valid", osc_valid, 0);
      check("R1 source", active_src, 0);
      check("R1 clk_en", clk_en, 0);

      // bring up CMOS mode and select external at once
      write_mode(3'b010);
      wait_valid(n);
      check("R4 setup settle", n, CS);
      write_sel(3'b001);
      check("R9 immediate select", active_src, 1);

      // sweep every mode code with the external source active
      for (int m = 0; m < 8; m++) begin
         int exp_n;
         write_mode(3'(m));
         check("R3 valid cleared", osc_valid, 0);
         if (m < 2) begin
            repeat (XS + 5) @(negedge clk);
            check("R2 off never valid", osc_valid, 0);
         end else begin
            wait_valid(n);
            check("R4 settle length", n, (m >= 6) ? XS : CS);
         end
         count_ext(5, n);
         exp_n = (m < 2) ? 0 : ((m == 3 || m == 7) ? 2 : 5);
         if (m < 2)                 check("R2 off no pulses", n, exp_n);
         else if (m == 3 || m == 7) check("R6 halved pulses", n, exp_n);
         else                       check("R5 pulse per edge", n, exp_n);
         check("R4 valid holds", osc_valid, (m < 2) ? 0 : 1);
      end

      // first divided pulse lands on the second edge
      write_mode(3'b111);
      wait_valid(n);
      count_ext(1, n);
      check("R6 first edge silent", n, 0);
      count_ext(1, n);
      check("R6 second edge pulses", n, 1);

      // other sources
      write_sel(3'b000); count_pattern(n); check("R7 internal", n, 24);
      write_sel(3'b010); count_pattern(n); check("R7 multiplier half", n, 6);
      write_sel(3'b011); count_pattern(n); check("R7 multiplier", n, 12);
      write_sel(3'b100); count_pattern(n); check("R7 low-frequency", n, 8);

      // reserved codes ignored
      for (int c = 5; c < 8; c++) begin
         write_sel(3'(c));
         check("R8 reserved ignored", active_src, 4);
      end
      count_pattern(n); check("R8 still low-frequency", n, 8);

      // held external request
      write_mode(3'b110);
      write_sel(3'b001);
      check("R9 held while invalid", active_src, 4);
      wait_valid(n);
      check("R9 not yet switched", active_src, 4);
      @(negedge clk);
      check("R9 switched after valid", active_src, 1);

      // cancelled external request
      write_mode(3'b110);
      write_sel(3'b001);
      write_sel(3'b000);
      check("R10 override lands", active_src, 0);
      wait_valid(n);
      repeat (3) @(negedge clk);
      check("R10 request dropped", active_src, 0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule